// File: doc/BRIEF.md
# Boot-Configurable Memory Remap Decoder

This block turns a CPU bus address into a one-hot target-region select and an offset local to that region. Three software-writable controls set the map. A mode field picks which memory shows up in the low window that starts at address zero. A flash-bank swap bit exchanges the two 1 MiB flash banks. An external swap field exchanges the SDRAM windows with the NOR/PSRAM window.

On reset the mode field takes its value from the boot-mode pins. The boot pins can place main flash, system flash or SRAM1 at address zero, but never the external memories. Software moves those to address zero with a later register write.

The decode is purely combinational from the register contents and the address. A register write is therefore seen by the first access after the clock edge that captures it. An address that lands in no mapped region raises a decode-error output in place of a region select.

Top module: `remap_decoder`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads the mode field from `boot_mode` if that code is 000, 001 or 011, and loads 000 for any other boot code. Each such edge also clears the flash-bank swap bit and the external swap field.
- R2: `rd_data` shows the mode in bits [2:0], the flash-bank swap in bit 8 and the external swap in bits [11:10]. Every other bit reads 0.
- R3: A write with mode code 101, 110 or 111 leaves the mode field unchanged. A write with swap code 10 or 11 leaves the swap field unchanged. The other fields of the same write still update.
- R4: Addresses 0x0000_0000 to 0x07FF_FFFF form the alias window, and the mode field picks its target:
  - 000: main flash
  - 001: system flash
  - 010: NOR/PSRAM
  - 011: SRAM1
  - 100: SDRAM bank 1
  
  The offset equals the address. An alias address beyond the target's size is a decode error.
- R5: Each flash bank is a 1 MiB window, and the offset is address bits [19:0].
  - Flash-bank swap bit 0: bank 1 is at 0x0800_0000 and bank 2 at 0x0810_0000.
  - Flash-bank swap bit 1: the two banks exchange places.
  - With mode 000, the alias at 0x0000_0000 and 0x0010_0000 follows the same bank order.
- R6: The external swap field sets the external windows. Each window is 256 MiB, and the offset is address bits [27:0].
  - Swap 00: NOR/PSRAM is at 0x6000_0000, SDRAM bank 1 at 0xC000_0000 and SDRAM bank 2 at 0xD000_0000. Addresses 0x7xxx_xxxx are unmapped.
  - Swap 01: SDRAM bank 1 is at 0x6000_0000, SDRAM bank 2 at 0x7000_0000 and NOR/PSRAM at 0xC000_0000. Addresses 0xDxxx_xxxx are unmapped.
- R7: System flash is 64 KiB at 0x1FFF_0000, and SRAM1 is 128 KiB at 0x2000_0000.
- R8: An address in no mapped region drives `dec_err` high, `region_sel` to 0 and `offset` to 0.
- R9: `region_sel` bits are assigned as follows, and at most one is high:
  - bit 0: flash bank 1
  - bit 1: flash bank 2
  - bit 2: system flash
  - bit 3: SRAM1
  - bit 4: NOR/PSRAM
  - bit 5: SDRAM bank 1
  - bit 6: SDRAM bank 2
  
  Decode follows the register in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; boot pins sampled while low |
| boot_mode | input | 3 | Boot-mode pins |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| addr | input | 32 | Bus address to decode |
| region_sel | output | 7 | One-hot target region |
| offset | output | 32 | Region-local offset |
| dec_err | output | 1 | Address maps to no region |

## Verification
Every boot code is tried, including the external-memory codes and the reserved codes, to separate a pass-through boot load from the filtered one. After each reset and after each register write, a fixed sweep of addresses is run. The sweep covers both edges of every window, the gaps between windows and the far end of the alias window, so that a window that is too large or too small shows up as a wrong select or a missing decode error. Register writes combine reserved and legal codes across the three fields, which shows whether the fields are filtered independently. Toggling each swap control with the alias in every mode shows whether the low window and the primary windows follow the same bank and window order.

// File: rtl/remap_decoder.sv
module remap_decoder #(
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter int          FLASH_AW   = 20,
  parameter logic [31:0] SYSF_BASE  = 32'h1FFF_0000,
  parameter int          SYSF_AW    = 16,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter int          SRAM_AW    = 17,
  parameter int          ALIAS_AW   = 27,
  parameter int          EXT_AW     = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  boot_mode,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [31:0] addr,
  output logic [6:0]  region_sel,
  output logic [31:0] offset,
  output logic        dec_err
);
  localparam int NREG = 7;
  localparam int R_FB1 = 0, R_FB2 = 1, R_SYSF = 2, R_SRAM = 3,
                 R_NOR = 4, R_SDR1 = 5, R_SDR2 = 6;
  localparam logic [31:0] FLASH_SPAN = 32'd1 << (FLASH_AW + 1);
  localparam logic [31:0] SYSF_SPAN  = 32'd1 << SYSF_AW;
  localparam logic [31:0] SRAM_SPAN  = 32'd1 << SRAM_AW;
  localparam logic [31:0] FMASK  = (32'd1 << FLASH_AW) - 32'd1;
  localparam logic [31:0] SMASK  = SYSF_SPAN - 32'd1;
  localparam logic [31:0] RMASK  = SRAM_SPAN - 32'd1;
  localparam logic [31:0] XMASK  = (32'd1 << EXT_AW) - 32'd1;
  localparam logic [3:0]  W_LO_A = 4'h6, W_LO_B = 4'h7, W_HI_A = 4'hC, W_HI_B = 4'hD;

  logic [2:0] mode_q;
  logic       fb_q;
  logic       es_q;
  logic       boot_ok;
  logic [NREG-1:0] sel;
  logic [31:0] off;
  logic        hit;

  assign boot_ok = (boot_mode == 3'd0) || (boot_mode == 3'd1) || (boot_mode == 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= boot_ok ? boot_mode : 3'd0;
      fb_q   <= 1'b0;
      es_q   <= 1'b0;
    end else if (wr_en) begin
      if (wr_data[2:0] <= 3'd4) mode_q <= wr_data[2:0];
      fb_q <= wr_data[8];
      if (!wr_data[11]) es_q <= wr_data[10];
    end
  end

  assign rd_data = {20'd0, 1'b0, es_q, 1'b0, fb_q, 5'd0, mode_q};

  always_comb begin
    sel = '0;
    off = '0;
    hit = 1'b0;
    if ((addr >> ALIAS_AW) == 32'd0) begin
      unique case (mode_q)
        3'd0: if (addr < FLASH_SPAN) begin
          hit = 1'b1;
          sel[(addr[FLASH_AW] ^ fb_q) ? R_FB2 : R_FB1] = 1'b1;
          off = addr & FMASK;
        end
        3'd1: if (addr < SYSF_SPAN) begin
          hit = 1'b1; sel[R_SYSF] = 1'b1; off = addr;
        end
        3'd2: begin hit = 1'b1; sel[R_NOR] = 1'b1; off = addr; end
        3'd3: if (addr < SRAM_SPAN) begin
          hit = 1'b1; sel[R_SRAM] = 1'b1; off = addr;
        end
        3'd4: begin hit = 1'b1; sel[R_SDR1] = 1'b1; off = addr; end
        default: ;
      endcase
    end else if ((addr >> (FLASH_AW + 1)) == (FLASH_BASE >> (FLASH_AW + 1))) begin
      hit = 1'b1;
      sel[(addr[FLASH_AW] ^ fb_q) ? R_FB2 : R_FB1] = 1'b1;
      off = addr & FMASK;
    end else if ((addr >> SYSF_AW) == (SYSF_BASE >> SYSF_AW)) begin
      hit = 1'b1; sel[R_SYSF] = 1'b1; off = addr & SMASK;
    end else if ((addr >> SRAM_AW) == (SRAM_BASE >> SRAM_AW)) begin
      hit = 1'b1; sel[R_SRAM] = 1'b1; off = addr & RMASK;
    end else begin
      case (addr[31:28])
        W_LO_A: begin hit = 1'b1; sel[es_q ? R_SDR1 : R_NOR] = 1'b1; off = addr & XMASK; end
        W_LO_B: if (es_q) begin hit = 1'b1; sel[R_SDR2] = 1'b1; off = addr & XMASK; end
        W_HI_A: begin hit = 1'b1; sel[es_q ? R_NOR : R_SDR1] = 1'b1; off = addr & XMASK; end
        W_HI_B: if (!es_q) begin hit = 1'b1; sel[R_SDR2] = 1'b1; off = addr & XMASK; end
        default: ;
      endcase
    end
  end

  assign region_sel = sel;
  assign offset     = off;
  assign dec_err    = !hit;

  p_boot_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data[2:0] == 3'd0 || rd_data[2:0] == 3'd1 || rd_data[2:0] == 3'd3));

  p_rsv_mode_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2:0] > 3'd4) |=> rd_data[2:0] == $past(rd_data[2:0]));

  p_rsv_swap_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[11]) |=> rd_data[11:10] == $past(rd_data[11:10]));

  p_legal_mode_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2:0] <= 3'd4) |=> rd_data[2:0] == $past(wr_data[2:0]));

  p_alias_nor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 32'd0 && rd_data[2:0] == 3'd2) |-> region_sel[R_NOR]);

  p_flash_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr >> (FLASH_AW + 1)) == (FLASH_BASE >> (FLASH_AW + 1))) |-> (region_sel[R_FB1] ^ region_sel[R_FB2]));

  p_ext_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[31:28] == W_LO_B && !rd_data[10]) |-> dec_err);

  p_sel_vs_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel) && (dec_err == (region_sel == '0)) && (!dec_err || offset == 32'd0));
endmodule

// File: tb/sim_remap_decoder.sv
module sim_remap_decoder;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  boot_mode = 3'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] addr = 32'd0;
  logic [31:0] rd_data;
  logic [6:0]  region_sel;
  logic [31:0] offset;
  logic        dec_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  int m_mode = 0;
  int m_fb = 0;
  int m_es = 0;

  remap_decoder u0 (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .addr(addr),
    .region_sel(region_sel), .offset(offset), .dec_err(dec_err)
  );

  always #(PERIOD/2) clk = ~clk;

  // Reference register model (R1, R3)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= (boot_mode == 0 || boot_mode == 1 || boot_mode == 3) ? int'(boot_mode) : 0;
      m_fb <= 0;
      m_es <= 0;
    end else if (wr_en) begin
      if (int'(wr_data[2:0]) < 5) m_mode <= int'(wr_data[2:0]);
      m_fb <= int'(wr_data[8]);
      if (int'(wr_data[11:10]) < 2) m_es <= int'(wr_data[11:10]);
    end
  end

  // Reference decode: region index 0..6 or -1 for none (R4..R9)
  function automatic void ref_dec(input logic [31:0] a, output int reg_i, output logic [31:0] o);
    longint ua = longint'(a);
    reg_i = -1; o = 0;
    if (ua < 64'h0800_0000) begin
      case (m_mode)
        0: if (ua < 64'h20_0000) begin
             reg_i = ((ua >= 64'h10_0000) != (m_fb == 1)) ? 1 : 0;
             o = a % 32'h10_0000;
           end
        1: if (ua < 64'h1_0000) begin reg_i = 2; o = a; end
        2: begin reg_i = 4; o = a; end
        3: if (ua < 64'h2_0000) begin reg_i = 3; o = a; end
        4: begin reg_i = 5; o = a; end
        default: ;
      endcase
    end else if (ua >= 64'h0800_0000 && ua < 64'h0820_0000) begin
      reg_i = ((ua >= 64'h0810_0000) != (m_fb == 1)) ? 1 : 0;
      o = a - 32'h0800_0000 - ((ua >= 64'h0810_0000) ? 32'h10_0000 : 0);
    end else if (ua >= 64'h1FFF_0000 && ua < 64'h2000_0000) begin
      reg_i = 2; o = a - 32'h1FFF_0000;
    end else if (ua >= 64'h2000_0000 && ua < 64'h2002_0000) begin
      reg_i = 3; o = a - 32'h2000_0000;
    end else if (ua >= 64'h6000_0000 && ua < 64'h7000_0000) begin
      reg_i = m_es ? 5 : 4; o = a - 32'h6000_0000;
    end else if (ua >= 64'h7000_0000 && ua < 64'h8000_0000) begin
      if (m_es == 1) begin reg_i = 6; o = a - 32'h7000_0000; end
    end else if (ua >= 64'hC000_0000 && ua < 64'hD000_0000) begin
      reg_i = m_es ? 4 : 5; o = a - 32'hC000_0000;
    end else if (ua >= 64'hD000_0000 && ua < 64'hE000_0000) begin
      if (m_es == 0) begin reg_i = 6; o = a - 32'hD000_0000; end
    end
  endfunction

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ri;
      logic [31:0] eo, erd;
      logic [6:0] esel;
      ref_dec(addr, ri, eo);
      esel = (ri < 0) ? 7'd0 : 7'(1 << ri);
      erd = 32'(m_mode) | (32'(m_fb) << 8) | (32'(m_es) << 10);
      n_cmp++;
      if (rd_data !== erd) begin
        n_bad++;
        $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, erd);
      end
      n_cmp++;
      if (region_sel !== esel || dec_err !== (ri < 0) || offset !== eo) begin
        n_bad++;
        $display("FAIL %s addr %h sel/err/off actual %b/%b/%h expected %b/%b/%h",
                 tag, addr, region_sel, dec_err, offset, esel, ri < 0, eo);
      end
    end
  end

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h000F_FFFC;  2: return 32'h0010_0000;
      3: return 32'h001F_FFFF;  4: return 32'h0020_0000;  5: return 32'h0000_FFFF;
      6: return 32'h0001_0000;  7: return 32'h0001_FFFF;  8: return 32'h0002_0000;
      9: return 32'h07FF_FFFF; 10: return 32'h0800_0000; 11: return 32'h080F_FFFF;
      12: return 32'h0810_0000; 13: return 32'h081F_FFF0; 14: return 32'h0820_0000;
      15: return 32'h1FFE_FFFF; 16: return 32'h1FFF_0000; 17: return 32'h1FFF_FFFF;
      18: return 32'h2000_0000; 19: return 32'h2001_FFFF; 20: return 32'h2002_0000;
      21: return 32'h6000_0004; 22: return 32'h7123_4567; 23: return 32'hC000_0010;
      24: return 32'hD0FF_0000; 25: return 32'hE000_0000; 26: return 32'h4000_0000;
      default: return 32'h5FFF_FFFF;
    endcase
  endfunction

  task automatic sweep();
    for (int i = 0; i < 28; i++) begin
      @(negedge clk); #1;
      addr = pick(i);
    end
  endtask

  task automatic do_reset(input logic [2:0] b);
    @(negedge clk); #1;
    rst_n = 1'b0; boot_mode = b; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = d; addr = 32'h0000_0000;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    // R1: every boot code, legal and filtered, then R4/R5/R7/R8 sweeps
    tag = "R1";
    for (int b = 0; b < 8; b++) begin
      do_reset(3'(b));
      sweep();
    end
    do_reset(3'd0);
    // R4: each alias mode; R9: decode follows the write next cycle
    tag = "R4";
    do_write(32'h0000_0002); sweep();
    do_write(32'h0000_0004); sweep();
    do_write(32'h0000_0003); sweep();
    do_write(32'h0000_0001); sweep();
    // R5: flash bank swap with flash alias
    tag = "R5";
    do_write(32'h0000_0100); sweep();
    do_write(32'h0000_0000); sweep();
    // R6: external window swap
    tag = "R6";
    do_write(32'h0000_0400); sweep();
    do_write(32'h0000_0402); sweep();
    do_write(32'h0000_0004); sweep();
    // R3: reserved codes ignored per field, others still land
    tag = "R3";
    do_write(32'h0000_0403); sweep();
    do_write(32'h0000_0905); sweep();
    do_write(32'h0000_0C06); sweep();
    do_write(32'h0000_0007); sweep();
    do_write(32'h0000_0801); sweep();
    // R2: reserved register bits written high still read zero
    tag = "R2";
    do_write(32'hFFFF_F2FA); sweep();
    do_write(32'hFFFF_F6F8); sweep();
    // R7/R8/R9: back-to-back writes with decode between
    tag = "R9";
    do_write(32'h0000_0000);
    do_write(32'h0000_0502);
    sweep();
    tag = "R8";
    do_write(32'h0000_0000); sweep();
    tag = "R7";
    do_write(32'h0000_0001); sweep();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL %s watchdog expired actual hung expected done", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule